// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is one channel of a free-running timer. It watches a shared counter value and an overflow pulse from the timer core. A 4-bit configuration sets it up for one of three jobs, or parks it. As an input-capture channel it samples an external pin and records the counter value on a chosen edge. As an output-compare channel it changes its output pin when the counter equals its 16-bit channel register. As a buffered output-compare/PWM channel it does the same from a register pair, where the new compare value only takes effect at the next counter overflow.

The configuration holds two mode bits and two edge/level bits. The same edge/level code means an edge choice in capture mode and a pin action in compare mode. When the edge/level code is zero the channel gives the pin back to port control and uses one mode bit as the preset output level. An overflow pulse drives the output to the level opposite the compare action, so a single compare value sets the PWM duty cycle. A channel event flag reports captures and matches. Software clears the flag by writing a one.

Top module: `tccp_channel`

## Requirements
- R1: `pin_own_o` is 1 exactly when the edge/level code is non-zero and at least one mode bit is set (output compare, buffered or not). It is 0 when the channel is parked or in input capture.
- R2: With edge/level code 00, `pin_o` takes the preset level on the clock after the configuration: low when mode bit A is 1 and high when it is 0. The level is kept when an output-compare mode is entered.
- R3: `cfg_wdata_i` packs {mode B, mode A, edge/level B, edge/level A} in bits [3:0], and `cfg_o` reads back in the same layout. The edge/level bits are written on any `cfg_we_i`. The mode bits are written only when `halt_i` is 1 in the same cycle and are otherwise left unchanged.
- R4: After reset the configuration is 0000, `pin_o` is 1, `pin_own_o` is 0, `flag_o` is 0 and `chreg_o` is 0.
- R5: In input capture (mode bits 00, edge/level code non-zero), code 01 captures rising edges only, 10 falling edges only and 11 both. The input passes two synchronising stages. A pin change in cycle N updates `chreg_o` and `flag_o` after the clock ending cycle N+2, and `chreg_o` takes the `cnt_i` value of that cycle.
- R6: In output compare, `cnt_i` equal to the active compare value in a cycle makes `pin_o` react on the next clock: code 01 toggles it, 10 drives 0 and 11 drives 1. In unbuffered mode a register write loads the active value directly.
- R7: `flag_o` is set on a capture or a compare match and is cleared by a `flag_clr_i` pulse. A new event in the same cycle as a clear wins.
- R8: In compare mode an `ovf_i` pulse drives `pin_o` to 1 for code 10 and to 0 for code 11, and leaves it unchanged for code 01. A match in the same cycle overrides the overflow action.
- R9: In buffered mode (mode B = 1) register writes go to a shadow register, and `chreg_o` keeps showing the active value. The shadow is copied to the active value on the clock of an `ovf_i` cycle.
- R10: `ovf_i` is asserted while `cnt_i` is 0. In clear mode, a compare value of 0 therefore holds `pin_o` at 0 for whole periods. A compare value the counter never reaches holds it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 16 | Shared timer counter value |
| ovf_i | input | 1 | Counter period start pulse (counter at 0) |
| halt_i | input | 1 | Timer stop; enables mode-bit writes |
| pin_i | input | 1 | Asynchronous channel input pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data {mode B, mode A, edge B, edge A} |
| reg_we_i | input | 1 | Channel register write strobe |
| reg_wdata_i | input | 16 | Channel register write data |
| flag_clr_i | input | 1 | Write-one clear of the event flag |
| pin_o | output | 1 | Channel output level |
| pin_own_o | output | 1 | 1 when the channel drives the pin |
| chreg_o | output | 16 | Active channel register (capture or compare value) |
| flag_o | output | 1 | Channel event flag |
| cfg_o | output | 4 | Configuration readback |

## Verification
The hardest case to reach is the buffered hand-over. Here a freshly written compare value must stay invisible until the overflow, while the old value is still matching. The stimulus writes a new value mid-period and lets the old value fire a clear. It then checks that the new value neither matches nor appears on `chreg_o` before the overflow, and that it governs the following period. Capture checks hold the counter steady across the two-stage synchroniser, so the latched value is known exactly. The duty-cycle extremes are driven over whole counter periods, with the overflow and a match landing in the same cycle.

// File: rtl/tccp_pkg.sv
// Package: shared types for the timer capture/compare channel.
// Holds the configuration layout and the decoded channel function.
package tccp_pkg;

    typedef struct packed {
        logic       msb;  // buffered compare select
        logic       msa;  // compare select / preset level
        logic [1:0] els;  // edge or action code
    } tccp_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_CMP     = 2'd2,
        CH_CMP_BUF = 2'd3
    } tccp_mode_e;

    // Turn the stored configuration into one channel function.
    function automatic tccp_mode_e tccp_decode(input tccp_cfg_t c);
        if (c.els == 2'b00)  return CH_OFF;
        else if (c.msb)      return CH_CMP_BUF;
        else if (c.msa)      return CH_CMP;
        else                 return CH_CAPTURE;
    endfunction

endpackage

// File: rtl/tccp_edge_sync.sv
// Module: input synchroniser and edge detector.
// Passes the asynchronous pin through STAGES flops and compares the last
// synchronised sample with the one before it. It assumes STAGES >= 2.
// Edges appear STAGES cycles after the pin changes.
module tccp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the pin sample along the chain, one extra stage for history.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
    end

    // Compare the synchronised sample with the previous one.
    always_comb begin
        rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

    // R5: a rising edge is a one-cycle pulse
    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R5: a falling edge is a one-cycle pulse
    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tccp_cmp_store.sv
// Module: channel register pair.
// Holds the active value, which is used for compare and loaded by capture,
// and a shadow used in buffered mode. Every register write also lands in the
// shadow, so entering buffered mode keeps the active value.
module tccp_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         buffered_i,
    input  logic         load_i,
    input  logic         cap_en_i,
    input  logic [W-1:0] cap_val_i,
    output logic [W-1:0] active_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Shadow copy of the last register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (wr_en_i) shadow_q <= wr_data_i;
    end

    // Active value: capture, then a direct write, then the buffered load.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active_q <= '0;
        else if (cap_en_i)               active_q <= cap_val_i;
        else if (wr_en_i && !buffered_i) active_q <= wr_data_i;
        else if (buffered_i && load_i)   active_q <= shadow_q;
    end

    assign active_o = active_q;

    // R9: the shadow moves into the active value at a period start
    assert_shadow_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && load_i && !cap_en_i) |=> (active_o == $past(shadow_q)));
    // R9: a buffered write alone leaves the active value untouched
    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && wr_en_i && !load_i && !cap_en_i) |=> $stable(active_o));

endmodule

// File: rtl/tccp_out_ctl.sv
// Module: output level control.
// Holds the channel output level. When parked it follows the preset level.
// In compare modes it applies the match action, and on a period start it
// applies the opposite of that action. A match wins over the period start.
module tccp_out_ctl
    import tccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tccp_mode_e mode_i,
    input  logic [1:0] els_i,
    input  logic       msa_i,
    input  logic       match_i,
    input  logic       ovf_i,
    output logic       level_o
);
    logic lvl_q;
    logic is_cmp;

    assign is_cmp = (mode_i == CH_CMP) || (mode_i == CH_CMP_BUF);

    // Next output level from the mode, the match and the period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else if (mode_i == CH_OFF) begin
            lvl_q <= ~msa_i;
        end else if (is_cmp) begin
            if (match_i) begin
                case (els_i)
                    2'b01:   lvl_q <= ~lvl_q;
                    2'b10:   lvl_q <= 1'b0;
                    2'b11:   lvl_q <= 1'b1;
                    default: lvl_q <= lvl_q;
                endcase
            end else if (ovf_i) begin
                case (els_i)
                    2'b10:   lvl_q <= 1'b1;
                    2'b11:   lvl_q <= 1'b0;
                    default: lvl_q <= lvl_q;
                endcase
            end
        end
    end

    assign level_o = lvl_q;

    // R2: a parked channel shows the preset level one clock later
    assert_off_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CH_OFF) |=> (level_o == !$past(msa_i)));
    // R8: a period start without a match sets the output in clear mode
    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && ovf_i && !match_i && els_i == 2'b10) |=> level_o);
    // R6: capture mode never moves the output
    assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CH_CAPTURE) |=> $stable(level_o));

endmodule

// File: rtl/tccp_channel.sv
// Module: timer capture/compare/PWM channel, top level.
// Stores the configuration (mode bits are written only while the timer is
// halted), decodes the channel function, and joins the input synchroniser,
// the register pair and the output control. It raises the event flag on
// captures and matches. It assumes ovf_i is high while cnt_i is zero.
module tccp_channel
    import tccp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic             halt_i,
    input  logic             pin_i,
    input  logic             cfg_we_i,
    input  logic [3:0]       cfg_wdata_i,
    input  logic             reg_we_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    input  logic             flag_clr_i,
    output logic             pin_o,
    output logic             pin_own_o,
    output logic [CNT_W-1:0] chreg_o,
    output logic             flag_o,
    output logic [3:0]       cfg_o
);
    tccp_cfg_t        cfg_q;
    tccp_mode_e       mode;
    logic             rise, fall, cap_hit, match, flag_q;
    logic [CNT_W-1:0] active;

    // Configuration: edge bits always writable, mode bits only when halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q.els <= cfg_wdata_i[1:0];
            if (halt_i) begin
                cfg_q.msa <= cfg_wdata_i[2];
                cfg_q.msb <= cfg_wdata_i[3];
            end
        end
    end

    // Decode the channel function from the stored configuration.
    always_comb mode = tccp_decode(cfg_q);

    tccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Select the capture edges from the edge code.
    always_comb begin
        cap_hit = (mode == CH_CAPTURE) &&
                  ((cfg_q.els[0] && rise) || (cfg_q.els[1] && fall));
    end

    tccp_cmp_store #(.W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_we_i),
        .wr_data_i  (reg_wdata_i),
        .buffered_i (mode == CH_CMP_BUF),
        .load_i     (ovf_i),
        .cap_en_i   (cap_hit),
        .cap_val_i  (cnt_i),
        .active_o   (active)
    );

    // Compare the counter with the active value in compare modes.
    always_comb begin
        match = ((mode == CH_CMP) || (mode == CH_CMP_BUF)) && (cnt_i == active);
    end

    tccp_out_ctl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .els_i   (cfg_q.els),
        .msa_i   (cfg_q.msa),
        .match_i (match),
        .ovf_i   (ovf_i),
        .level_o (pin_o)
    );

    // Event flag: a new event beats a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (cap_hit || match) flag_q <= 1'b1;
        else if (flag_clr_i)       flag_q <= 1'b0;
    end

    assign flag_o    = flag_q;
    assign chreg_o   = active;
    assign cfg_o     = cfg_q;
    assign pin_own_o = (mode == CH_CMP) || (mode == CH_CMP_BUF);

    // R3: the mode bits never change without the halt input
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_i |=> (cfg_o[3:2] == $past(cfg_o[3:2])));
    // R7: a match always leaves the flag set
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_o);
    // R7: a clear with no new event drops the flag
    assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !match && !cap_hit) |=> !flag_o);
    // R5: a capture loads the counter value into the channel register
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (chreg_o == $past(cnt_i)));

endmodule

// File: tb/test_tccp_channel.sv
// Scoreboard bench: the driver queues expected outputs with a due cycle,
// and the monitor compares them at the falling edge of that cycle.
module test_tccp_channel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam int K_PIN = 0, K_OWN = 1, K_FLAG = 2, K_REG = 3, K_CFG = 4;

    typedef struct {
        int          due;
        int          kind;
        logic [15:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic        ovf_i = 0, halt_i = 0, pin_i = 0;
    logic        cfg_we_i = 0, reg_we_i = 0, flag_clr_i = 0;
    logic [3:0]  cfg_wdata_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic        pin_o, pin_own_o, flag_o;
    logic [15:0] chreg_o;
    logic [3:0]  cfg_o;

    int   cyc = 0, checks = 0, errors = 0;
    bit   done = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tccp_channel i_tccp_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ovf_i(ovf_i), .halt_i(halt_i),
        .pin_i(pin_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .flag_clr_i(flag_clr_i),
        .pin_o(pin_o), .pin_own_o(pin_own_o), .chreg_o(chreg_o), .flag_o(flag_o),
        .cfg_o(cfg_o)
    );

    // Monitor: pop every expectation that is due and compare it.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [15:0] act;
                case (sb[i].kind)
                    K_PIN:   act = {15'd0, pin_o};
                    K_OWN:   act = {15'd0, pin_own_o};
                    K_FLAG:  act = {15'd0, flag_o};
                    K_REG:   act = chreg_o;
                    default: act = {12'd0, cfg_o};
                endcase
                checks++;
                if (act !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s kind %0d cycle %0d: actual %h expected %h",
                             sb[i].tag, sb[i].kind, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int d, input int kind, input logic [15:0] v,
                             input string tag);
        exp_t e;
        e.due = cyc + d; e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cfg_we_i = 0; reg_we_i = 0; flag_clr_i = 0; ovf_i = 0; halt_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_cfg(input logic [3:0] v);
        cfg_we_i = 1; halt_i = 1; cfg_wdata_i = v; tick();
    endtask

    task automatic write_reg(input logic [15:0] v);
        reg_we_i = 1; reg_wdata_i = v; tick();
    endtask

    task automatic clear_flag();
        flag_clr_i = 1; tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_n = 1; tick();
        // R4: reset state
        expect_at(0, K_PIN, 16'd1, "R4"); expect_at(0, K_OWN, 16'd0, "R4");
        expect_at(0, K_FLAG, 16'd0, "R4"); expect_at(0, K_REG, 16'd0, "R4");
        expect_at(0, K_CFG, 16'd0, "R4");
        tick();

        // R3: mode bit write without halt is ignored
        cfg_we_i = 1; halt_i = 0; cfg_wdata_i = 4'b0100;
        expect_at(1, K_CFG, 16'd0, "R3"); expect_at(2, K_PIN, 16'd1, "R3");
        ticks(3);

        // R2: preset low, pin stays with the port
        set_cfg(4'b0100);
        expect_at(0, K_CFG, 16'h4, "R3");
        expect_at(1, K_PIN, 16'd0, "R2"); expect_at(1, K_OWN, 16'd0, "R1");
        ticks(2);

        // R5: rising-edge capture
        set_cfg(4'b0001);
        expect_at(0, K_OWN, 16'd0, "R1");
        cnt_i = 16'h1234; pin_i = 1;
        expect_at(3, K_REG, 16'h1234, "R5"); expect_at(3, K_FLAG, 16'd1, "R7");
        expect_at(2, K_FLAG, 16'd0, "R5");
        ticks(4);
        clear_flag();
        expect_at(0, K_FLAG, 16'd0, "R7");
        cnt_i = 16'h2222; pin_i = 0;
        expect_at(4, K_REG, 16'h1234, "R5"); expect_at(4, K_FLAG, 16'd0, "R5");
        ticks(5);

        // R5: falling-edge capture ignores the rising edge
        set_cfg(4'b0010);
        cnt_i = 16'h0BEE; pin_i = 1;
        expect_at(4, K_REG, 16'h1234, "R5");
        ticks(5);
        pin_i = 0;
        expect_at(3, K_REG, 16'h0BEE, "R5"); expect_at(3, K_FLAG, 16'd1, "R7");
        ticks(4);
        clear_flag();

        // R5: both edges
        set_cfg(4'b0011);
        cnt_i = 16'h0C0C; pin_i = 1;
        expect_at(3, K_REG, 16'h0C0C, "R5");
        ticks(4);
        cnt_i = 16'h0D0D; pin_i = 0;
        expect_at(3, K_REG, 16'h0D0D, "R5");
        ticks(4);
        clear_flag();

        // R2/R6: preset low kept, toggle on match
        set_cfg(4'b0100); tick();
        set_cfg(4'b0101);
        expect_at(0, K_OWN, 16'd1, "R1"); expect_at(0, K_PIN, 16'd0, "R2");
        cnt_i = 16'd0; write_reg(16'd5);
        expect_at(0, K_REG, 16'd5, "R6");
        cnt_i = 16'd5;
        expect_at(1, K_PIN, 16'd1, "R6"); expect_at(1, K_FLAG, 16'd1, "R7");
        tick();
        cnt_i = 16'd6; flag_clr_i = 1;
        expect_at(1, K_PIN, 16'd1, "R6"); expect_at(1, K_FLAG, 16'd0, "R7");
        tick();
        cnt_i = 16'd0; ovf_i = 1;
        expect_at(1, K_PIN, 16'd1, "R8");
        tick();
        cnt_i = 16'd5;
        expect_at(1, K_PIN, 16'd0, "R6");
        tick();
        cnt_i = 16'd5; flag_clr_i = 1;
        expect_at(1, K_FLAG, 16'd1, "R7");
        tick();
        cnt_i = 16'd6; clear_flag();

        // R6/R8: clear-on-match PWM
        set_cfg(4'b0110);
        write_reg(16'd3);
        cnt_i = 16'd0; ovf_i = 1;
        expect_at(1, K_PIN, 16'd1, "R8");
        tick();
        cnt_i = 16'd2;
        expect_at(1, K_PIN, 16'd1, "R6");
        tick();
        cnt_i = 16'd3;
        expect_at(1, K_PIN, 16'd0, "R6");
        tick();
        cnt_i = 16'd4; tick();

        // R10: compare 0 gives 0% duty
        write_reg(16'd0);
        for (int p = 0; p < 16; p++) begin
            cnt_i = 16'(p % 8); ovf_i = (p % 8 == 0);
            expect_at(1, K_PIN, 16'd0, "R10");
            tick();
        end
        // R10: compare never reached gives 100% duty
        write_reg(16'hFFFF);
        for (int p = 0; p < 16; p++) begin
            cnt_i = 16'(p % 8); ovf_i = (p % 8 == 0);
            expect_at(1, K_PIN, 16'd1, "R10");
            tick();
        end

        // R6/R8: set-on-match
        set_cfg(4'b0111);
        write_reg(16'd2);
        cnt_i = 16'd0; ovf_i = 1;
        expect_at(1, K_PIN, 16'd0, "R8");
        tick();
        cnt_i = 16'd2;
        expect_at(1, K_PIN, 16'd1, "R6");
        tick();
        cnt_i = 16'd3; tick();

        // R9: buffered clear-on-match
        set_cfg(4'b1010);
        expect_at(0, K_OWN, 16'd1, "R1");
        write_reg(16'd6);
        expect_at(0, K_REG, 16'd2, "R9");
        cnt_i = 16'd2;
        expect_at(1, K_PIN, 16'd0, "R9");
        tick();
        cnt_i = 16'd6;
        expect_at(1, K_REG, 16'd2, "R9");
        tick();
        cnt_i = 16'd0; ovf_i = 1;
        expect_at(1, K_PIN, 16'd1, "R8"); expect_at(1, K_REG, 16'd6, "R9");
        tick();
        cnt_i = 16'd2;
        expect_at(1, K_PIN, 16'd1, "R9");
        tick();
        cnt_i = 16'd6;
        expect_at(1, K_PIN, 16'd0, "R9");
        tick();
        cnt_i = 16'd7;
        ticks(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule